// File: doc/BRIEF.md
# Avionics Serial Word Manchester Encoder

This block turns one 16-bit payload into a single 20-bit-time word for a command/response avionics serial bus. A word opens with a 3-bit-time sync pattern that is not Manchester coded. Its polarity marks the word type: command/status or data. The sync is followed by the 16 payload bits in Manchester II bi-phase form, most significant bit first, and then one odd-parity bit that is coded the same way.

The encoder runs from a single clock at twice the bit rate, so every clock is one half-bit. The line is a pair of phase outputs, positive and negative, plus a transmit-enable. When idle, both phases rest at the null level. A start strobe captures the payload and the word type. The encoder then drives 40 half-bits. A one-cycle done flag marks the final half-bit. A start given in that cycle chains the next word with no idle half-bit between them, so a message can be sent as one contiguous stream.

Top module: `avx_word_encoder`

## Requirements
- R1: After reset and whenever no word is in flight, line_pos, line_neg, tx_en, busy and done are all 0.
- R2: A start seen at a clock edge while idle begins a word whose first half-bit appears in the following cycle. tx_en and busy are then 1 for exactly 40 consecutive cycles.
- R3: With word_is_data=0 (command/status), half-bits 0–2 have line_pos=1 and half-bits 3–5 have line_pos=0.
- R4: With word_is_data=1 (data), half-bits 0–2 have line_pos=0 and half-bits 3–5 have line_pos=1.
- R5: Payload bit 15 down to bit 0 occupy half-bit pairs 6/7 through 36/37. A 1 is sent as line_pos high then low, and a 0 as low then high.
- R6: Half-bits 38/39 carry a parity bit chosen so that the payload plus parity holds an odd number of ones. It is Manchester coded like a payload bit.
- R7: While tx_en is 1, line_neg is always the complement of line_pos.
- R8: A start during half-bits 0–38 of a word is ignored, and the word in flight is unchanged.
- R9: done is 1 only during half-bit 39. A start in that cycle makes the next word's half-bit 0 follow at once, with no gap.
- R10: payload and word_is_data are sampled only when a start is accepted. Changing them during a word has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock, twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send a word |
| word_is_data | input | 1 | 1 selects data sync, 0 selects command/status sync |
| payload | input | 16 | Information field |
| line_pos | output | 1 | Positive line phase |
| line_neg | output | 1 | Negative line phase |
| tx_en | output | 1 | Transmitter enable |
| busy | output | 1 | Word in flight |
| done | output | 1 | Final half-bit of the word |

## Verification
The hardest case to reach is the boundary between chained words. A start must be accepted in exactly the done cycle and refused one cycle earlier, while the payload inputs keep changing under a word in flight. The stimulus places starts on the done cycle, on the half-bit before it and in mid-word, with altered payload and type. It also runs random words with random gaps. A behavioural queue model predicts every half-bit, and the bench compares against it on every clock.

// File: rtl/avx_word_encoder.sv
module avx_word_encoder #(
  parameter int DW     = 16,
  parameter int SYNC_B = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          word_is_data,
  input  logic [DW-1:0] payload,
  output logic          line_pos,
  output logic          line_neg,
  output logic          tx_en,
  output logic          busy,
  output logic          done
);
  localparam int HALVES = 2 * (SYNC_B + DW + 1);
  localparam int SW     = $clog2(HALVES);
  localparam logic [SW-1:0] LAST_H  = SW'(HALVES - 1);
  localparam logic [SW-1:0] SYNC_HH = SW'(SYNC_B);
  localparam logic [SW-1:0] DATA0   = SW'(2 * SYNC_B);

  logic [SW-1:0] slot;
  logic          busy_q, is_data_q;
  logic [DW:0]   sr;

  wire last    = busy_q && (slot == LAST_H);
  wire accept  = start && (!busy_q || last);
  wire in_sync = slot < DATA0;
  wire lvl     = in_sync ? ((slot < SYNC_HH) ^ is_data_q) : (sr[DW] ^ slot[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      slot      <= '0;
      is_data_q <= 1'b0;
      sr        <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      slot      <= '0;
      is_data_q <= word_is_data;
      sr        <= {payload, ~^payload};
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      slot <= slot + 1'b1;
      if (!in_sync && slot[0]) sr <= sr << 1;
    end
  end

  assign line_pos = busy_q & lvl;
  assign line_neg = busy_q & ~lvl;
  assign tx_en    = busy_q;
  assign busy     = busy_q;
  assign done     = last;

  AST_IDLE_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!line_pos && !line_neg && !done)); // R1
  AST_PAIR_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (line_pos != line_neg)); // R7
  AST_MID_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !in_sync && slot[0]) |-> (line_pos != $past(line_pos))); // R5
  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_sync && slot != '0 && slot != SYNC_HH) |-> $stable(line_pos)); // R3
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy); // R9
  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (busy && !done)); // R9
endmodule

// File: tb/avx_word_encoder_tb.sv
module avx_word_encoder_tb;
  logic clk = 0, rst_n = 0, start = 0, word_is_data = 0;
  logic [15:0] payload = '0;
  logic line_pos, line_neg, tx_en, busy, done;
  int checks = 0, failures = 0;
  bit exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  avx_word_encoder u_dut (.clk(clk), .rst_n(rst_n), .start(start), .word_is_data(word_is_data),
    .payload(payload), .line_pos(line_pos), .line_neg(line_neg), .tx_en(tx_en), .busy(busy), .done(done));

  task automatic push_word(input logic [15:0] d, input bit isd);
    for (int h = 0; h < 6; h++) begin
      exp_q.push_back((h < 3) ^ isd);
      tag_q.push_back(isd ? "R4" : "R3");
    end
    for (int b = 15; b >= 0; b--) begin
      exp_q.push_back(d[b]);  tag_q.push_back("R5");
      exp_q.push_back(!d[b]); tag_q.push_back("R5");
    end
    exp_q.push_back(~^d);  tag_q.push_back("R6");
    exp_q.push_back(^d);   tag_q.push_back("R6");
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete(); tag_q.delete();
    end else begin
      bit acc;
      acc = start && (exp_q.size() <= 1);
      if (exp_q.size() > 0) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
      if (acc) push_word(payload, word_is_data);
    end
  end

  task automatic fail(input string r, input string what, input int act, input int exp);
    failures++;
    $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
  endtask

  task automatic compare();
    bit act_on;
    act_on = exp_q.size() > 0;
    checks++;
    if (!act_on) begin
      if ({line_pos, line_neg, tx_en, busy, done} != 5'b0)
        fail("R1", "idle outputs", {line_pos, line_neg, tx_en, busy, done}, 0);
    end else begin
      if (tx_en !== 1'b1 || busy !== 1'b1) fail("R2", "tx_en/busy", {tx_en, busy}, 3);
      if (line_pos !== exp_q[0]) fail(tag_q[0], "line_pos", line_pos, exp_q[0]);
      if (line_neg !== !exp_q[0]) fail("R7", "line_neg", line_neg, !exp_q[0]);
      if (done !== (exp_q.size() == 1)) fail("R9", "done", done, exp_q.size() == 1);
    end
  endtask

  task automatic step(input bit s, input logic [15:0] d, input bit isd);
    @(negedge clk);
    compare();
    start = s; payload = d; word_is_data = isd;
  endtask

  task automatic idle_until_free();
    while (exp_q.size() > 0) step(0, $urandom, $urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({line_pos, line_neg, tx_en, busy, done} != 5'b0) fail("R1", "reset outputs", {line_pos, line_neg, tx_en, busy, done}, 0);
    rst_n = 1;
    step(0, 0, 0);
    // R3 command word, R2 length
    step(1, 16'hA5C3, 0);
    idle_until_free();
    // R4 data word, R6 parity with even count
    step(1, 16'h0003, 1);
    idle_until_free();
    step(1, 16'hFFFF, 0);
    idle_until_free();
    step(1, 16'h0000, 1);
    idle_until_free();
    // R8 starts mid-word and on half-bit 38; R10 inputs change mid-word
    step(1, 16'h1234, 0);
    for (int i = 0; i < 38; i++) step((i % 7) == 3, 16'hBEEF ^ 16'(i), i[0]);
    step(1, 16'h5555, 1);  // this start falls on half-bit 38: ignored
    step(0, 0, 0);
    idle_until_free();
    // R9 chained words started in the done cycle
    step(1, 16'h8001, 1);
    for (int w = 0; w < 4; w++) begin
      while (exp_q.size() != 1) step(0, $urandom, $urandom);
      step(1, 16'($urandom), 1'($urandom));
    end
    idle_until_free();
    // random words and gaps
    for (int w = 0; w < 30; w++) begin
      step(1, 16'($urandom), 1'($urandom));
      while (exp_q.size() > 1) step(($urandom % 5) == 0, 16'($urandom), 1'($urandom));
      repeat ($urandom % 3) step(($urandom % 2) == 0, 16'($urandom), 1'($urandom));
    end
    idle_until_free();
    step(0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule